// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a simple internal request port and an external asynchronous static RAM of 32768 bytes. The RAM has a 15-bit address, a shared 8-bit data bus, and three active-low strobes for select, write and output enable. An internal master presents one request at a time: a read, or a write with its data. The controller turns that request into a strobe sequence and counts system clocks so that every minimum access, pulse and setup time of the chosen speed grade is met.

The speed grade and the clock period are parameters. Each timing figure becomes a clock count: the time divided by the period, rounded up, and never less than one. Writes are controlled by write enable. Write enable and chip select fall on the same clock edge, so the RAM never turns its outputs on during a write. Output enable stays high for the whole write. The controller drives the data bus only while the write strobe is low and for one clock after it. Read data comes back with a one-clock valid pulse. Between cycles chip select is high, which keeps the RAM in standby.

The data bus is split into an output value, an output enable and an input value. The tristate pad sits outside this block.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is active, and in every idle cycle after it, mem_cs_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0 and req_ready is 1.
- R2: A read keeps mem_cs_n=0, mem_oe_n=0 and mem_we_n=1 for RD cycles. It captures mem_dq_in on the clock edge that ends the last of those cycles. rd_valid is 1 exactly RD cycles after the accepting edge, and rd_data then holds the byte the RAM returned.
- R3: On a write, mem_we_n and mem_cs_n fall on the same edge, both stay low for exactly WR cycles and rise together, and mem_oe_n stays 1 the whole time.
- R4: mem_dq_oe is 1 while mem_we_n is low and for the one cycle after the strobes rise, and 0 otherwise. It is never 1 while mem_oe_n is 0.
- R5: mem_addr does not change while mem_cs_n stays low.
- R6: After a write is accepted, req_ready returns to 1 exactly WR+REC cycles later, where REC = max(1, ceil(tWC/T) - WR).
- R7: Counts use ceil(ns/T) with a minimum of 1. RD = max of the read cycle count and the output-enable access count. WR = max of write pulse, select setup, address setup to write-enable rise, and data setup. Grade 0 uses 100/50 ns for reads and 100/70/80/80/40 ns for writes; grade 1 uses 120/60 and 120/80/90/90/45; grade 2 uses 150/75 and 150/90/100/100/50. At T=8 ns and grade 1 this gives RD=15, WR=12 and REC=3.
- R8: A request is taken only on an edge where req_ready is 1. req_ready drops on the cycle after acceptance. A request held while busy leaves the current cycle's address and strobes untouched and is served after the current cycle ends.
- R9: When a cycle ends, mem_cs_n is 1 for at least one cycle before the next access.
- R10: rd_valid is a single-cycle pulse, and rd_data keeps its value until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Idle and accepting a request |
| rd_valid | output | 1 | One-cycle pulse: rd_data is new |
| rd_data | output | 8 | Captured read byte |
| mem_addr | output | 15 | RAM address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_out | output | 8 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Enable for the data pad driver |
| mem_dq_in | input | 8 | Data from the RAM pad |

## Verification
The bench uses grade 1 at 8 ns. A read's rd_valid is due on the 15th clock after the accepting edge. A write's req_ready is due on the 15th clock, with the strobes low for 12 of those clocks and the bus held for one clock after them. The bench counts clock edges from acceptance and samples on the falling edge, so each count lands on a settled value. Its RAM model returns the stored byte only in the final cycle of the read window and returns a junk byte before that, so a read window that is too short or badly placed shows up as wrong data. A monitor runs on every falling edge and checks strobe widths, ordering, address stability and bus ownership.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_READ = 2'd1,
    SEQ_WLOW = 2'd2,
    SEQ_WREC = 2'd3
  } seq_state_e;

  typedef enum logic [2:0] {
    TP_CYC_RD = 3'd0,
    TP_OE_ACC = 3'd1,
    TP_CYC_WR = 3'd2,
    TP_WE_PW  = 3'd3,
    TP_CS_SU  = 3'd4,
    TP_AD_SU  = 3'd5,
    TP_DA_SU  = 3'd6
  } tparam_e;

  function automatic int unsigned pick3(input int unsigned grade, input int unsigned g0,
                                        input int unsigned g1, input int unsigned g2);
    if (grade == 0) return g0;
    else if (grade == 1) return g1;
    return g2;
  endfunction

  function automatic int unsigned grade_ns(input int unsigned grade, input tparam_e p);
    case (p)
      TP_CYC_RD: return pick3(grade, 100, 120, 150);
      TP_OE_ACC: return pick3(grade, 50, 60, 75);
      TP_CYC_WR: return pick3(grade, 100, 120, 150);
      TP_WE_PW:  return pick3(grade, 70, 80, 90);
      TP_CS_SU:  return pick3(grade, 80, 90, 100);
      TP_AD_SU:  return pick3(grade, 80, 90, 100);
      TP_DA_SU:  return pick3(grade, 40, 45, 50);
      default:   return pick3(grade, 100, 120, 150);
    endcase
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned tcyc(input int unsigned grade, input tparam_e p,
                                       input int unsigned per);
    return ns_to_cyc(grade_ns(grade, p), per);
  endfunction

  function automatic int unsigned rd_cycles(input int unsigned grade, input int unsigned per);
    return max2(tcyc(grade, TP_CYC_RD, per), tcyc(grade, TP_OE_ACC, per));
  endfunction

  function automatic int unsigned wr_cycles(input int unsigned grade, input int unsigned per);
    return max2(max2(tcyc(grade, TP_WE_PW, per), tcyc(grade, TP_CS_SU, per)),
                max2(tcyc(grade, TP_AD_SU, per), tcyc(grade, TP_DA_SU, per)));
  endfunction

  function automatic int unsigned rec_cycles(input int unsigned grade, input int unsigned per);
    int unsigned wc;
    int unsigned wl;
    wc = tcyc(grade, TP_CYC_WR, per);
    wl = wr_cycles(grade, per);
    return (wc > wl + 1) ? (wc - wl) : 1;
  endfunction

endpackage

// File: rtl/sram_req_regs.sv
module sram_req_regs #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);

  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    addr_d = addr_q;
    data_d = data_q;
    if (load) begin
      addr_d = addr_in;
      data_d = data_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [DATA_W-1:0] data_d;

  always_comb begin
    data_d = rd_data;
    if (sample) data_d = dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_data  <= data_d;
      rd_valid <= sample;
    end
  end

  // R10: the valid flag lasts one cycle, and the data holds once the flag is gone
  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  a_r10_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |=> $stable(rd_data));

endmodule

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC  = 13,
  parameter int unsigned WR_CYC  = 10,
  parameter int unsigned REC_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic accept,
  output logic rd_sample,
  output logic cs_n,
  output logic we_n,
  output logic oe_n,
  output logic dq_oe
);

  localparam int unsigned MAX_CYC = max2(max2(RD_CYC, WR_CYC), REC_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;

  assign cnt_zero  = (cnt_q == '0);
  assign req_ready = (state_q == SEQ_IDLE);
  assign accept    = req_valid && req_ready;
  assign rd_sample = (state_q == SEQ_READ) && cnt_zero;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      SEQ_IDLE: begin
        if (accept) begin
          if (req_write) begin
            state_d = SEQ_WLOW;
            cnt_d   = CNT_W'(WR_CYC - 1);
          end else begin
            state_d = SEQ_READ;
            cnt_d   = CNT_W'(RD_CYC - 1);
          end
        end
      end
      SEQ_READ: begin
        if (cnt_zero) state_d = SEQ_IDLE;
        else cnt_d = cnt_q - CNT_W'(1);
      end
      SEQ_WLOW: begin
        if (cnt_zero) begin
          state_d = SEQ_WREC;
          cnt_d   = CNT_W'(REC_CYC - 1);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      SEQ_WREC: begin
        if (cnt_zero) state_d = SEQ_IDLE;
        else cnt_d = cnt_q - CNT_W'(1);
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      cs_n    <= 1'b1;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      dq_oe   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cs_n    <= !((state_d == SEQ_READ) || (state_d == SEQ_WLOW));
      we_n    <= (state_d != SEQ_WLOW);
      oe_n    <= (state_d != SEQ_READ);
      dq_oe   <= (state_d == SEQ_WLOW) || ((state_d == SEQ_WREC) && (state_q == SEQ_WLOW));
    end
  end

  // R1: an idle sequencer leaves every strobe off and the bus released
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n && we_n && oe_n && !dq_oe));
  // R8: taking a request makes the port busy on the next cycle
  a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R3: the write strobe falls together with chip select, with output enable off
  a_r3_we_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> $fell(cs_n));
  a_r3_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);
  // R2: a read has select and output enable low and the write strobe high
  a_r2_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!cs_n && we_n));
  // R4: the data driver never overlaps the RAM output stage
  a_r4_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);
  a_r4_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned SPEED_GRADE   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned RD_CYC  = rd_cycles(SPEED_GRADE, CLK_PERIOD_NS);
  localparam int unsigned WR_CYC  = wr_cycles(SPEED_GRADE, CLK_PERIOD_NS);
  localparam int unsigned REC_CYC = rec_cycles(SPEED_GRADE, CLK_PERIOD_NS);

  logic rst_meta, rst_sync;
  logic accept, rd_sample;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  sram_strobe_seq #(
    .RD_CYC (RD_CYC),
    .WR_CYC (WR_CYC),
    .REC_CYC(REC_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_ready(req_ready),
    .accept   (accept),
    .rd_sample(rd_sample),
    .cs_n     (mem_cs_n),
    .we_n     (mem_we_n),
    .oe_n     (mem_oe_n),
    .dq_oe    (mem_dq_oe)
  );

  sram_req_regs #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_req (
    .clk    (clk),
    .rst_n  (rst_sync),
    .load   (accept),
    .addr_in(req_addr),
    .data_in(req_wdata),
    .addr_q (mem_addr),
    .data_q (mem_dq_out)
  );

  sram_rd_capture #(
    .DATA_W(DATA_W)
  ) u_cap (
    .clk     (clk),
    .rst_n   (rst_sync),
    .sample  (rd_sample),
    .dq_in   (mem_dq_in),
    .rd_data (rd_data),
    .rd_valid(rd_valid)
  );

  // R5: the address register holds while the RAM stays selected
  a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_sync)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
  // R9: a new access starts only after chip select has been high
  a_r9_cs_gap: assert property (@(posedge clk) disable iff (!rst_sync)
    $fell(mem_cs_n) |-> $past(req_ready));
  // R4: write data stays put while it is driven
  a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_sync)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

endmodule

// File: tb/sram_async_ctrl_test.sv
module sram_async_ctrl_test;

  localparam int unsigned GRADE = 1;
  localparam int unsigned TPER  = 8;

  function automatic int unsigned cdiv(input int unsigned ns);
    int unsigned c;
    c = (ns + TPER - 1) / TPER;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int unsigned mx(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // R7: grade 1 figures from the requirement table
  localparam int unsigned RD_E  = mx(cdiv(120), cdiv(60));
  localparam int unsigned WR_E  = mx(mx(cdiv(80), cdiv(90)), mx(cdiv(90), cdiv(45)));
  localparam int unsigned REC_E = (cdiv(120) > WR_E + 1) ? cdiv(120) - WR_E : 1;

  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [14:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready, rd_valid;
  logic [7:0]  rd_data;
  logic [14:0] mem_addr;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  int checks;
  int failures;

  sram_async_ctrl #(
    .CLK_PERIOD_NS(TPER),
    .SPEED_GRADE  (GRADE)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] init_val(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h3C;
  endfunction

  logic [7:0] model_mem [int];
  logic [7:0] exp_mem [int];

  function automatic logic [7:0] model_rd(input logic [14:0] a);
    return model_mem.exists(int'(a)) ? model_mem[int'(a)] : init_val(a);
  endfunction
  function automatic logic [7:0] exp_rd(input logic [14:0] a);
    return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : init_val(a);
  endfunction

  // RAM model and protocol monitor, on the falling edge
  int          rdlow, wlow;
  bit          prev_cs, prev_we, hold_chk, bad_oe;
  logic [14:0] prev_addr;
  logic [7:0]  wcap, dq_drive;
  assign mem_dq_in = dq_drive;

  always @(negedge clk) begin
    if (!rst_n) begin
      rdlow = 0; wlow = 0; prev_cs = 1; prev_we = 1; hold_chk = 0; bad_oe = 0;
      prev_addr = '0; wcap = 8'h00; dq_drive = 8'hEE;
    end else begin
      if (!mem_cs_n && mem_we_n && !mem_oe_n) rdlow++;
      else rdlow = 0;
      dq_drive = (rdlow == RD_E) ? model_rd(mem_addr) : (8'h5A ^ 8'(rdlow));
      if (!mem_we_n && prev_we)
        check(!mem_cs_n && prev_cs, "R3 we/cs fall together", int'(mem_cs_n), 0);
      if (mem_dq_oe) check(mem_oe_n, "R4 bus driven with oe low", int'(mem_oe_n), 1);
      if (!mem_cs_n && !prev_cs)
        check(mem_addr == prev_addr, "R5 address stable", int'(mem_addr), int'(prev_addr));
      if (!mem_cs_n && !mem_we_n) begin
        wlow++;
        if (mem_dq_oe) wcap = mem_dq_out;
        if (!mem_oe_n) bad_oe = 1;
      end else if (wlow > 0) begin
        check(wlow == int'(WR_E), "R3 write low width", wlow, int'(WR_E));
        check(mem_cs_n && mem_we_n, "R3 strobes rise together", int'({mem_cs_n, mem_we_n}), 3);
        check(!bad_oe, "R3 oe high during write", int'(bad_oe), 0);
        check(mem_dq_oe, "R4 data held one cycle", int'(mem_dq_oe), 1);
        model_mem[int'(mem_addr)] = wcap;
        wlow = 0; bad_oe = 0; hold_chk = 1;
      end else if (hold_chk) begin
        check(!mem_dq_oe, "R4 bus released", int'(mem_dq_oe), 0);
        hold_chk = 0;
      end
      prev_cs = mem_cs_n; prev_we = mem_we_n; prev_addr = mem_addr;
    end
  end

  task automatic do_op(input bit wr, input logic [14:0] a, input logic [7:0] d);
    bit done;
    logic [7:0] held;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R8 ready drops after accept", int'(req_ready), 0);
    if (wr) exp_mem[int'(a)] = d;
    done = 0;
    for (int i = 1; i <= 100 && !done; i++) begin
      @(negedge clk);
      if (!wr && rd_valid) begin
        done = 1;
        check(i == int'(RD_E), "R2 R7 read latency", i, int'(RD_E));
        check(rd_data == exp_rd(a), "R2 read data", int'(rd_data), int'(exp_rd(a)));
        check(mem_cs_n, "R9 cs high after read", int'(mem_cs_n), 1);
        held = rd_data;
        @(negedge clk);
        check(!rd_valid, "R10 single pulse", int'(rd_valid), 0);
        check(rd_data == held, "R10 data held", int'(rd_data), int'(held));
      end else if (wr && req_ready) begin
        done = 1;
        check(i == int'(WR_E + REC_E), "R6 R7 write cycle length", i, int'(WR_E + REC_E));
        check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 R9 idle after write",
              int'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}), 14);
      end
    end
    if (!done) check(0, "R2 R6 op never completed", 0, 1);
  endtask

  task automatic busy_test(input logic [14:0] a1, input logic [14:0] a2, input logic [7:0] d);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a1; req_wdata = 8'h00;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_write = 1'b1; req_addr = a2; req_wdata = d;
    n = 0;
    while (!req_ready && n < 100) begin
      check(mem_addr == a1 && mem_we_n, "R8 pending request held off",
            int'(mem_addr), int'(a1));
      n++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(rd_valid && rd_data == exp_rd(a1), "R8 R2 first op result",
          int'(rd_data), int'(exp_rd(a1)));
    do_op(1'b1, a2, d);
  endtask

  initial begin
    checks = 0; failures = 0;
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [14:0] pool [8];
    void'($urandom(32'd51977));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 strobes in reset",
          int'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}), 14);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready && !rd_valid, "R1 ready after reset", int'({req_ready, rd_valid}), 2);
    check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 idle strobes",
          int'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}), 14);

    // directed corners
    do_op(1'b0, 15'h0000, 8'h00);
    do_op(1'b1, 15'h7FFF, 8'hFF);
    do_op(1'b0, 15'h7FFF, 8'h00);
    do_op(1'b1, 15'h0000, 8'h00);
    do_op(1'b0, 15'h0000, 8'h00);
    do_op(1'b1, 15'h2AAA, 8'h55);
    do_op(1'b0, 15'h2AAA, 8'h00);
    busy_test(15'h7FFF, 15'h1234, 8'hA7);
    do_op(1'b0, 15'h1234, 8'h00);

    // random mix over a small address pool
    for (int i = 0; i < 8; i++) pool[i] = 15'(i * 4099 + 7);
    for (int k = 0; k < 60; k++) begin
      logic [14:0] a;
      a = pool[$urandom % 8];
      do_op(1'($urandom % 2), a, 8'($urandom));
    end

    repeat (3) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule